// File: doc/BRIEF.md
# Vector Length Configuration Unit

This block executes the instruction that sets up a vector loop. From the decoded instruction fields, the operand values and the current 64-bit vector state word, it works out a new maximum length, a new vector length, the updated state word and an optional register write-back. The write-back carries a zero-extended value and its destination index. The whole calculation is combinational. Its results are captured in output registers one cycle after an input strobe.

The vector length comes from one of four sources. The first match in this order wins: the length already held in the state word, the low bits of the RA operand, the low bits of the count register, and the instruction immediate. The immediate encodes the requested length minus one. The chosen length is then limited, as an unsigned number, to the maximum length.

When the vertical-first flag is set and neither the length-source flag nor the max-set flag is set, the instruction is a step operation. In that case the state word is returned unchanged, and a step value computed elsewhere is routed to the destination register.

Top module: `vlset_unit`

## Requirements
- R1: While `rst` is high and on the first clock after it, `out_valid` and `wb_en` are 0 and `state_out` is all zeros.
- R2: Every result appears on the outputs in the clock cycle after the edge that samples `in_valid` high. `out_valid` is high in exactly those cycles. Back-to-back strobes give back-to-back results.
- R3: When `vs_flag` is 0, the new vector length is the length field already held in `state_in`.
- R4: When `vs_flag` is 1 and `ra_idx` is non-zero, the vector length is `ra_opnd[6:0]`. The upper operand bits are ignored.
- R5: When `vs_flag` is 1, `ra_idx` is 0 and `rt_idx` is non-zero, the vector length is `ctr_opnd[6:0]`.
- R6: When `vs_flag` is 1 and both indices are 0, the vector length is `imm_field + 1` truncated to 7 bits, so an immediate of 127 gives 0.
- R7: When `ms_flag` is 1, the maximum length is `imm_field + 1` truncated to 7 bits. Otherwise it is the maximum field already held in `state_in`.
- R8: If the selected vector length is greater than the maximum length in an unsigned compare, it is replaced by the maximum length.
- R9: In the state word, bits [63:57] hold the maximum length and bits [56:50] hold the vector length. Bit [1] is the persist flag and bit [0] is the vertical-first flag. Bits [49:2] pass through from `state_in` unchanged. `maxlen_out` and `vl_out` report the two length fields.
- R10: When `rt_idx` is non-zero, `wb_en` is 1, `wb_idx` equals `rt_idx` and `wb_data` is the final vector length zero-extended to 64 bits. When `rt_idx` is 0, `wb_en` is 0.
- R11: When `vs_flag` and `ms_flag` are both 0, bits [1:0] of the state word keep their old values. Otherwise bit [0] takes `vf_flag` and bit [1] is cleared.
- R12: When `vf_flag` is 1 and `vs_flag` and `ms_flag` are both 0, `state_out` equals `state_in` and the length outputs report the old fields. The write-back, if `rt_idx` is non-zero, carries `step_val` zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe, one cycle per instruction |
| rt_idx | input | 5 | Destination register index |
| ra_idx | input | 5 | Source register index |
| imm_field | input | 7 | Immediate, requested length minus one |
| vf_flag | input | 1 | Vertical-first request |
| vs_flag | input | 1 | Take length from a source other than the state word |
| ms_flag | input | 1 | Set the maximum length from the immediate |
| ra_opnd | input | 64 | Value of the RA register |
| ctr_opnd | input | 64 | Value of the count register |
| step_val | input | 7 | Precomputed step for the step operation |
| state_in | input | 64 | Current vector state word |
| out_valid | output | 1 | Registered result valid |
| wb_en | output | 1 | Register write-back requested |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 64 | Write-back value |
| state_out | output | 64 | Updated vector state word |
| maxlen_out | output | 7 | Resulting maximum length |
| vl_out | output | 7 | Resulting vector length |

## Verification
Every result is due exactly one clock after the edge that captures `in_valid`. This holds for the state word, both length outputs and all three write-back outputs. The driver task raises the strobe on a falling edge and pushes the expected result into a queue at that moment. The monitor samples on the next falling edge where `out_valid` is high, which falls between the capturing edge and the following one. It pops one entry per valid cycle, so back-to-back strobes are matched in order. A valid cycle with an empty queue is reported as a failure against R2, and so is a queue still holding entries at the end of the run.

// File: rtl/vlset_pkg.sv
`timescale 1ns/1ps
package vlset_pkg;

  // Source chosen for the new vector length, in priority order.
  typedef enum logic [1:0] {
    VSRC_OLD = 2'd0,
    VSRC_RA  = 2'd1,
    VSRC_CTR = 2'd2,
    VSRC_IMM = 2'd3
  } vsrc_e;

  // LSB-0 positions of the two single-bit mode flags in the state word.
  localparam int unsigned VF_POS      = 0;
  localparam int unsigned PERSIST_POS = 1;

endpackage

// File: rtl/vlset_src_sel.sv
`timescale 1ns/1ps
module vlset_src_sel
  import vlset_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned IDX_W = 5
) (
  input  logic             vs,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [LEN_W-1:0] ra_low,
  input  logic [LEN_W-1:0] ctr_low,
  input  logic [LEN_W-1:0] imm_len,
  input  logic [LEN_W-1:0] old_vl,
  output logic [LEN_W-1:0] vl_req
);

  vsrc_e src;

  always_comb begin
    if (!vs)
      src = VSRC_OLD;
    else if (ra_idx != '0)
      src = VSRC_RA;
    else if (rt_idx != '0)
      src = VSRC_CTR;
    else
      src = VSRC_IMM;
  end

  always_comb begin
    unique case (src)
      VSRC_OLD: vl_req = old_vl;
      VSRC_RA:  vl_req = ra_low;
      VSRC_CTR: vl_req = ctr_low;
      default:  vl_req = imm_len;
    endcase
  end

endmodule

// File: rtl/vlset_limit.sv
`timescale 1ns/1ps
module vlset_limit #(
  parameter int unsigned LEN_W = 7
) (
  input  logic             ms,
  input  logic [LEN_W-1:0] imm_len,
  input  logic [LEN_W-1:0] old_max,
  input  logic [LEN_W-1:0] vl_req,
  output logic [LEN_W-1:0] max_new,
  output logic [LEN_W-1:0] vl_new
);

  assign max_new = ms ? imm_len : old_max;

  // Unsigned compare: both operands are plain logic vectors.
  assign vl_new = (vl_req > max_new) ? max_new : vl_req;

endmodule

// File: rtl/vlset_state_pack.sv
`timescale 1ns/1ps
module vlset_state_pack
  import vlset_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = 7
) (
  input  logic [XLEN-1:0]  state_in,
  input  logic [LEN_W-1:0] max_new,
  input  logic [LEN_W-1:0] vl_new,
  input  logic             vf,
  input  logic             mode_upd,
  input  logic             step_case,
  output logic [XLEN-1:0]  state_new
);

  localparam int unsigned MAX_LO = XLEN - LEN_W;
  localparam int unsigned VL_LO  = XLEN - 2*LEN_W;

  always_comb begin
    state_new = state_in;
    if (!step_case) begin
      state_new[MAX_LO +: LEN_W] = max_new;
      state_new[VL_LO  +: LEN_W] = vl_new;
      if (mode_upd) begin
        state_new[VF_POS]      = vf;
        state_new[PERSIST_POS] = 1'b0;
      end
    end
  end

endmodule

// File: rtl/vlset_unit.sv
`timescale 1ns/1ps
module vlset_unit #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned LEN_W = 7,
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] rt_idx,
  input  logic [IDX_W-1:0] ra_idx,
  input  logic [LEN_W-1:0] imm_field,
  input  logic             vf_flag,
  input  logic             vs_flag,
  input  logic             ms_flag,
  input  logic [XLEN-1:0]  ra_opnd,
  input  logic [XLEN-1:0]  ctr_opnd,
  input  logic [LEN_W-1:0] step_val,
  input  logic [XLEN-1:0]  state_in,
  output logic             out_valid,
  output logic             wb_en,
  output logic [IDX_W-1:0] wb_idx,
  output logic [XLEN-1:0]  wb_data,
  output logic [XLEN-1:0]  state_out,
  output logic [LEN_W-1:0] maxlen_out,
  output logic [LEN_W-1:0] vl_out
);

  localparam int unsigned MAX_LO = XLEN - LEN_W;
  localparam int unsigned VL_LO  = XLEN - 2*LEN_W;
  localparam int unsigned PAD_W  = XLEN - LEN_W;

  logic [LEN_W-1:0] imm_len, old_max, old_vl, vl_req, max_new, vl_new;
  logic [LEN_W-1:0] len_sel, max_sel;
  logic [XLEN-1:0]  state_new, wb_next;
  logic             step_case, mode_upd;
  logic             unused_opnd_hi;

  assign unused_opnd_hi = ^{ra_opnd[XLEN-1:LEN_W], ctr_opnd[XLEN-1:LEN_W]};

  assign imm_len   = imm_field + {{(LEN_W-1){1'b0}}, 1'b1};
  assign old_max   = state_in[MAX_LO +: LEN_W];
  assign old_vl    = state_in[VL_LO  +: LEN_W];
  assign step_case = vf_flag & ~vs_flag & ~ms_flag;
  assign mode_upd  = vs_flag | ms_flag;

  vlset_src_sel #(.LEN_W(LEN_W), .IDX_W(IDX_W)) u_src (
    .vs      (vs_flag),
    .ra_idx  (ra_idx),
    .rt_idx  (rt_idx),
    .ra_low  (ra_opnd[LEN_W-1:0]),
    .ctr_low (ctr_opnd[LEN_W-1:0]),
    .imm_len (imm_len),
    .old_vl  (old_vl),
    .vl_req  (vl_req)
  );

  vlset_limit #(.LEN_W(LEN_W)) u_lim (
    .ms      (ms_flag),
    .imm_len (imm_len),
    .old_max (old_max),
    .vl_req  (vl_req),
    .max_new (max_new),
    .vl_new  (vl_new)
  );

  vlset_state_pack #(.XLEN(XLEN), .LEN_W(LEN_W)) u_pack (
    .state_in  (state_in),
    .max_new   (max_new),
    .vl_new    (vl_new),
    .vf        (vf_flag),
    .mode_upd  (mode_upd),
    .step_case (step_case),
    .state_new (state_new)
  );

  assign len_sel = step_case ? old_vl  : vl_new;
  assign max_sel = step_case ? old_max : max_new;
  assign wb_next = step_case ? {{PAD_W{1'b0}}, step_val}
                             : {{PAD_W{1'b0}}, vl_new};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      wb_en      <= 1'b0;
      wb_idx     <= '0;
      wb_data    <= '0;
      state_out  <= '0;
      maxlen_out <= '0;
      vl_out     <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid && (rt_idx != '0);
      if (in_valid) begin
        wb_idx     <= rt_idx;
        wb_data    <= wb_next;
        state_out  <= state_new;
        maxlen_out <= max_sel;
        vl_out     <= len_sel;
      end
    end
  end

  // ---------------- assertions ----------------
  AST_VALID_FOLLOWS_STROBE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid)); // R2

  AST_VL_WITHIN_MAX: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !$past(step_case)) |-> (vl_out <= maxlen_out)); // R8

  AST_WB_NEEDS_INDEX: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (out_valid && wb_idx != '0)); // R10

  AST_WB_ZERO_EXTENDED: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> (wb_data[XLEN-1:LEN_W] == '0)); // R10

  AST_STEP_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(vf_flag && !vs_flag && !ms_flag))
      |-> (state_out == $past(state_in))); // R12

  AST_MODE_BITS_LOADED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(vs_flag || ms_flag))
      |-> (state_out[1] == 1'b0 && state_out[0] == $past(vf_flag))); // R11

  AST_MAX_FROM_IMM: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(ms_flag))
      |-> (maxlen_out == LEN_W'($past(imm_field) + 1'b1))); // R7

endmodule

// File: tb/tb_vlset_unit.sv
`timescale 1ns/1ps
module tb_vlset_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [4:0]  rt_idx, ra_idx;
  logic [6:0]  imm_field, step_val;
  logic        vf_flag, vs_flag, ms_flag;
  logic [63:0] ra_opnd, ctr_opnd, state_in;
  logic        out_valid, wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data, state_out;
  logic [6:0]  maxlen_out, vl_out;

  always #2 clk = ~clk; // 250 MHz

  vlset_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .rt_idx(rt_idx), .ra_idx(ra_idx),
    .imm_field(imm_field), .vf_flag(vf_flag), .vs_flag(vs_flag), .ms_flag(ms_flag),
    .ra_opnd(ra_opnd), .ctr_opnd(ctr_opnd), .step_val(step_val), .state_in(state_in),
    .out_valid(out_valid), .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .state_out(state_out), .maxlen_out(maxlen_out), .vl_out(vl_out)
  );

  typedef struct {
    logic [63:0] st;
    logic        wbe;
    logic [4:0]  wbi;
    logic [63:0] wbd;
    logic [6:0]  mx;
    logic [6:0]  vl;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 1'b0;

  // Expected result computed from the requirements.
  function automatic exp_t model(string tag, logic [4:0] rt, logic [4:0] ra,
                                 logic [6:0] imm, logic vf, logic vs, logic ms,
                                 logic [63:0] rav, logic [63:0] ctrv,
                                 logic [6:0] stp, logic [63:0] st);
    exp_t e;
    logic [6:0] len, omax, ovl, mx, vl;
    len  = imm + 7'd1;
    omax = st[63:57];
    ovl  = st[56:50];
    e.tag = tag;
    e.wbe = (rt != 0);
    e.wbi = rt;
    if (vf && !vs && !ms) begin
      e.st = st; e.mx = omax; e.vl = ovl;
      e.wbd = {57'd0, stp};
    end else begin
      if (!vs)          vl = ovl;
      else if (ra != 0) vl = rav[6:0];
      else if (rt != 0) vl = ctrv[6:0];
      else              vl = len;
      mx = ms ? len : omax;
      if (vl > mx) vl = mx;
      e.st = st;
      e.st[63:57] = mx;
      e.st[56:50] = vl;
      if (vs || ms) begin
        e.st[0] = vf;
        e.st[1] = 1'b0;
      end
      e.mx = mx; e.vl = vl;
      e.wbd = {57'd0, vl};
    end
    return e;
  endfunction

  function automatic logic [63:0] mkstate(logic [6:0] mx, logic [6:0] vl, logic [47:0] mid, logic [1:0] lo);
    return {mx, vl, mid, lo};
  endfunction

  // Driver: raise the strobe on a falling edge, push the expectation.
  task automatic apply(string tag, logic [4:0] rt, logic [4:0] ra, logic [6:0] imm,
                       logic vf, logic vs, logic ms, logic [63:0] rav,
                       logic [63:0] ctrv, logic [6:0] stp, logic [63:0] st);
    @(negedge clk);
    rt_idx = rt; ra_idx = ra; imm_field = imm;
    vf_flag = vf; vs_flag = vs; ms_flag = ms;
    ra_opnd = rav; ctr_opnd = ctrv; step_val = stp; state_in = st;
    in_valid = 1'b1;
    exp_q.push_back(model(tag, rt, ra, imm, vf, vs, ms, rav, ctrv, stp, st));
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // Monitor: compare on the falling edge after the capturing edge.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (exp_q.size() == 0) begin
        vectors++; miscompares++;
        $display("FAIL R2: out_valid act=1 exp=0 with no pending vector");
      end else begin
        exp_t e;
        bit bad;
        e = exp_q.pop_front();
        bad = 1'b0;
        vectors++;
        if (state_out !== e.st) begin
          bad = 1'b1;
          $display("FAIL %s: state_out act=%h exp=%h", e.tag, state_out, e.st);
        end
        if (maxlen_out !== e.mx) begin
          bad = 1'b1;
          $display("FAIL %s: maxlen_out act=%0d exp=%0d", e.tag, maxlen_out, e.mx);
        end
        if (vl_out !== e.vl) begin
          bad = 1'b1;
          $display("FAIL %s: vl_out act=%0d exp=%0d", e.tag, vl_out, e.vl);
        end
        if (wb_en !== e.wbe) begin
          bad = 1'b1;
          $display("FAIL %s: wb_en act=%b exp=%b", e.tag, wb_en, e.wbe);
        end else if (e.wbe && (wb_idx !== e.wbi || wb_data !== e.wbd)) begin
          bad = 1'b1;
          $display("FAIL %s: wb act=%0d/%h exp=%0d/%h", e.tag, wb_idx, wb_data, e.wbi, e.wbd);
        end
        if (bad) miscompares++;
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0;
    rt_idx = '0; ra_idx = '0; imm_field = '0; step_val = '0;
    vf_flag = 0; vs_flag = 0; ms_flag = 0;
    ra_opnd = '0; ctr_opnd = '0; state_in = 64'hFFFF_FFFF_FFFF_FFFF;
    repeat (3) @(negedge clk);
    // R1: reset state
    vectors++;
    if (out_valid !== 1'b0 || wb_en !== 1'b0 || state_out !== 64'd0) begin
      miscompares++;
      $display("FAIL R1: act=%b/%b/%h exp=0/0/0", out_valid, wb_en, state_out);
    end
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if (out_valid !== 1'b0 || wb_en !== 1'b0 || state_out !== 64'd0) begin
      miscompares++;
      $display("FAIL R1: after release act=%b/%b/%h exp=0/0/0", out_valid, wb_en, state_out);
    end

    // R7 R8: max from immediate 2, old VL 10 clamped
    apply("R8", 5'd1, 5'd0, 7'd1, 0, 0, 1, 64'd0, 64'd0, 7'd0,
          mkstate(7'd10, 7'd10, 48'h0, 2'b00));
    idle(2);
    // R3 R11: length from state, mode bits untouched
    apply("R3", 5'd3, 5'd6, 7'd50, 0, 0, 0, 64'd99, 64'd88, 7'd0,
          mkstate(7'd20, 7'd5, 48'h0, 2'b11));
    idle(1);
    // R4: from RA low bits, upper bits ignored
    apply("R4", 5'd2, 5'd4, 7'd99, 0, 1, 1, 64'hFFFF_FFFF_FFFF_FFB7, 64'd3, 7'd0,
          mkstate(7'd1, 7'd1, 48'h0, 2'b00));
    idle(1);
    // R5 R7: from count register, max kept from state
    apply("R5", 5'd7, 5'd0, 7'd3, 0, 1, 0, 64'd60, 64'hAAAA_0000_0000_000C, 7'd0,
          mkstate(7'd40, 7'd2, 48'h0, 2'b10));
    idle(1);
    // R6 R10: immediate length, no write-back
    apply("R6", 5'd0, 5'd0, 7'd15, 1, 1, 1, 64'd77, 64'd66, 7'd0,
          mkstate(7'd0, 7'd0, 48'h0, 2'b10));
    idle(1);
    // R6: immediate 127 wraps to length 0
    apply("R6", 5'd0, 5'd0, 7'd127, 0, 1, 1, 64'd0, 64'd0, 7'd0,
          mkstate(7'd64, 7'd33, 48'h0, 2'b01));
    idle(1);
    // R8: RA value 100 limited to old max 30
    apply("R8", 5'd9, 5'd2, 7'd0, 0, 1, 0, 64'hFFFF_0000_0000_0064, 64'd0, 7'd0,
          mkstate(7'd30, 7'd4, 48'h0, 2'b00));
    idle(1);
    // R12: step operation with write-back
    apply("R12", 5'd9, 5'd0, 7'd5, 1, 0, 0, 64'd1, 64'd2, 7'd17,
          mkstate(7'd12, 7'd9, 48'hDEAD_BEEF_1234, 2'b11));
    idle(1);
    // R12: step operation without write-back
    apply("R12", 5'd0, 5'd3, 7'd5, 1, 0, 0, 64'd1, 64'd2, 7'd99,
          mkstate(7'd12, 7'd3, 48'h0F0F_0F0F_0F0F, 2'b10));
    idle(1);
    // R11: vertical-first loaded, persist cleared
    apply("R11", 5'd5, 5'd0, 7'd7, 1, 1, 0, 64'd0, 64'd6, 7'd0,
          mkstate(7'd50, 7'd50, 48'h0, 2'b10));
    idle(1);
    // R9: middle bits pass through
    apply("R9", 5'd31, 5'd0, 7'd63, 0, 0, 1, 64'd0, 64'd0, 7'd0,
          mkstate(7'd127, 7'd100, 48'hA5A5_5A5A_C3C3, 2'b01));
    idle(1);
    // R2: back-to-back strobes
    apply("R2", 5'd1, 5'd1, 7'd9, 0, 1, 1, 64'd4, 64'd0, 7'd0,
          mkstate(7'd0, 7'd0, 48'h0, 2'b00));
    apply("R2", 5'd2, 5'd0, 7'd9, 0, 1, 1, 64'd0, 64'd8, 7'd0,
          mkstate(7'd0, 7'd0, 48'h0, 2'b00));
    apply("R2", 5'd0, 5'd0, 7'd9, 0, 1, 1, 64'd0, 64'd0, 7'd0,
          mkstate(7'd0, 7'd0, 48'h0, 2'b00));
    idle(4);

    if (exp_q.size() != 0) begin
      vectors++; miscompares++;
      $display("FAIL R2: pending act=%0d exp=0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule